// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the 16-bit operand offset and the segment choice for a memory operand in a real-mode core that uses 16-bit segments. A request names which terms to use: an optional displacement (8-bit signed or 16-bit), an optional base register (BX or BP) and an optional index register (SI or DI). It may also name a segment that overrides the default. The block adds the chosen terms modulo 2^16 and picks the stack segment when BP takes part, or the data segment otherwise. It then forms the 20-bit physical address from the segment value and the offset.

The work is done one term per clock. A request with more terms therefore completes later, and a request with one term finishes in a single cycle. A start pulse latches the request and the register values. Busy stays high while the sum is being built, and a one-cycle done pulse then presents the result. The results stay on the outputs until the next request completes. A base or index code outside the legal set, or a request with no terms at all, completes at once with the illegal flag set and every address output at zero.

Top module: `seg_ea_gen`

## Requirements
- R1: The offset `ea` is the sum of the present terms taken modulo 2^16. Example: BX=0010h with a 16-bit displacement FFFFh gives 000Fh.
- R2: When registers are present and `disp_wide`=0, the displacement is `disp[7:0]` sign-extended to 16 bits. When `disp_wide`=1, all 16 bits of `disp` are used.
- R3: A displacement-only request (no base, no index) always uses all 16 bits of `disp`, whatever `disp_wide` is.
- R4: `base_sel` encodes 0 = none, 1 = BX, 2 = BP. `idx_sel` encodes 0 = none, 1 = SI, 2 = DI. Register values are latched on the accepted start.
- R5: A request is illegal if `base_sel`=3, if `idx_sel`=3, or if it has no term. It then completes with `illegal`=1 and `ea`, `phys` and `seg_sel` all zero, one cycle after start.
- R6: Segment codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS. With no override, a request that uses BP selects SS (2) and every other request selects DS (3).
- R7: When `seg_ovr_en`=1, `seg_sel` is `seg_ovr_sel` and the override replaces the default.
- R8: `phys` equals (selected segment value × 16 + `ea`) mod 2^20.
- R9: `done` is a one-cycle pulse that rises N clock edges after the edge that accepts start, where N is the number of terms (1, 2 or 3). `busy` is high from the cycle after acceptance until `done` rises.
- R10: A start asserted while `busy` is high is ignored. It produces no extra completion and does not change the result in flight.
- R11: After reset, `busy`, `done`, `illegal`, `ea`, `seg_sel` and `phys` are all zero.
- R12: The result outputs keep their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| disp_en | input | 1 | Displacement term present |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: signed 8-bit |
| disp | input | 16 | Displacement value |
| base_sel | input | 2 | Base select: 0 none, 1 BX, 2 BP, 3 illegal |
| idx_sel | input | 2 | Index select: 0 none, 1 SI, 2 DI, 3 illegal |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr_sel | input | 2 | Override segment code: 0 ES, 1 CS, 2 SS, 3 DS |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed request was illegal |
| ea | output | 16 | Effective address offset |
| seg_sel | output | 2 | Selected segment code |
| phys | output | 20 | Physical address |

## Verification
Each result is due N cycles after the accepting edge, where N is 1, 2 or 3 depending on the number of terms, and an illegal request is always due after 1 cycle. The driver records the cycle number of the accepting edge together with the expected values and the expected term count. The monitor samples on the falling edge. When it sees done, it checks the offset, segment code, physical address and illegal flag, and it checks that the elapsed cycle count equals the term count. A start raised during a busy window pushes nothing into the queue, so any extra done shows up as a miscompare. The bench also checks that the queue is empty at the end.

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int AW = 16,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          disp_en,
  input  logic          disp_wide,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    idx_sel,
  input  logic          seg_ovr_en,
  input  logic [1:0]    seg_ovr_sel,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  input  logic [AW-1:0] seg_es,
  input  logic [AW-1:0] seg_cs,
  input  logic [AW-1:0] seg_ss,
  input  logic [AW-1:0] seg_ds,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg_sel,
  output logic [PW-1:0] phys
);
  localparam int SH = PW - AW;

  logic          accept;
  logic          has_base, has_idx, bad, regs_used;
  logic [AW-1:0] disp_x, base_v, idx_v;
  logic [1:0]    seg_code;
  logic [AW-1:0] seg_val;
  logic [1:0]    n_terms;

  logic [AW-1:0] t_disp, t_base, t_idx, acc, seg_q;
  logic [2:0]    mask;
  logic [1:0]    cnt, code_q;
  logic          bad_q;
  logic [AW-1:0] term, sum;

  assign accept    = start && !busy;
  assign has_base  = (base_sel == 2'd1) || (base_sel == 2'd2);
  assign has_idx   = (idx_sel == 2'd1) || (idx_sel == 2'd2);
  assign regs_used = (base_sel != 2'd0) || (idx_sel != 2'd0);
  assign bad       = (base_sel == 2'd3) || (idx_sel == 2'd3) ||
                     (!disp_en && !regs_used);

  assign disp_x  = (disp_wide || !regs_used) ? disp :
                   {{(AW-8){disp[7]}}, disp[7:0]};
  assign base_v  = (base_sel == 2'd2) ? reg_bp : reg_bx;
  assign idx_v   = (idx_sel == 2'd2) ? reg_di : reg_si;
  assign n_terms = 2'(disp_en) + 2'(has_base) + 2'(has_idx);

  assign seg_code = seg_ovr_en ? seg_ovr_sel :
                    (base_sel == 2'd2) ? 2'd2 : 2'd3;

  always_comb begin
    case (seg_code)
      2'd0:    seg_val = seg_es;
      2'd1:    seg_val = seg_cs;
      2'd2:    seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end

  always_comb begin
    if (mask[0])      term = t_disp;
    else if (mask[1]) term = t_base;
    else if (mask[2]) term = t_idx;
    else              term = '0;
  end

  assign sum = acc + term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      ea      <= '0;
      seg_sel <= '0;
      phys    <= '0;
      acc     <= '0;
      mask    <= '0;
      cnt     <= '0;
      t_disp  <= '0;
      t_base  <= '0;
      t_idx   <= '0;
      seg_q   <= '0;
      code_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        acc    <= '0;
        t_disp <= disp_x;
        t_base <= base_v;
        t_idx  <= idx_v;
        seg_q  <= seg_val;
        code_q <= seg_code;
        bad_q  <= bad;
        mask   <= bad ? 3'b000 : {has_idx, has_base, disp_en};
        cnt    <= bad ? 2'd1 : n_terms;
      end else if (busy) begin
        acc <= sum;
        if (mask[0])      mask[0] <= 1'b0;
        else if (mask[1]) mask[1] <= 1'b0;
        else              mask[2] <= 1'b0;
        cnt <= cnt - 2'd1;
        if (cnt == 2'd1) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          illegal <= bad_q;
          if (bad_q) begin
            ea      <= '0;
            seg_sel <= '0;
            phys    <= '0;
          end else begin
            ea      <= sum;
            seg_sel <= code_q;
            phys    <= {seg_q, {SH{1'b0}}} + {{SH{1'b0}}, sum};
          end
        end
      end
    end
  end
endmodule

module seg_ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        disp_en,
  input logic [1:0]  base_sel,
  input logic [1:0]  idx_sel,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic [15:0] ea,
  input logic [19:0] phys,
  input logic [1:0]  seg_sel
);
  logic [2:0] lat_cnt, exp_lat;
  logic       hb, hi, bd;

  assign hb = (base_sel == 2'd1) || (base_sel == 2'd2);
  assign hi = (idx_sel == 2'd1) || (idx_sel == 2'd2);
  assign bd = (base_sel == 2'd3) || (idx_sel == 2'd3) ||
              (!disp_en && base_sel == 2'd0 && idx_sel == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      exp_lat <= '0;
    end else if (start && !busy) begin
      lat_cnt <= '0;
      exp_lat <= bd ? 3'd1 : 3'(disp_en) + 3'(hb) + 3'(hi);
    end else if (lat_cnt != 3'd7) begin
      lat_cnt <= lat_cnt + 3'd1;
    end
  end

  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == exp_lat); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy || done); // R9
  AST_NO_DONE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done); // R10
  AST_ILLEGAL_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (ea == 16'h0 && phys == 20'h0 && seg_sel == 2'd0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ea) && $stable(phys) && $stable(illegal)); // R12
endmodule

bind seg_ea_gen seg_ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .disp_en(disp_en),
  .base_sel(base_sel), .idx_sel(idx_sel), .busy(busy), .done(done),
  .illegal(illegal), .ea(ea), .phys(phys), .seg_sel(seg_sel)
);

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, disp_en = 1'b0, disp_wide = 1'b0, seg_ovr_en = 1'b0;
  logic [15:0] disp = '0;
  logic [1:0] base_sel = '0, idx_sel = '0, seg_ovr_sel = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0;
  logic [15:0] es = '0, cs = '0, ss = '0, ds = '0;
  logic busy, done, illegal;
  logic [15:0] ea;
  logic [1:0] seg_sel;
  logic [19:0] phys;

  seg_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .disp_en(disp_en),
    .disp_wide(disp_wide), .disp(disp), .base_sel(base_sel), .idx_sel(idx_sel),
    .seg_ovr_en(seg_ovr_en), .seg_ovr_sel(seg_ovr_sel),
    .reg_bx(bx), .reg_bp(bp), .reg_si(si), .reg_di(di),
    .seg_es(es), .seg_cs(cs), .seg_ss(ss), .seg_ds(ds),
    .busy(busy), .done(done), .illegal(illegal), .ea(ea),
    .seg_sel(seg_sel), .phys(phys)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] ea;
    logic [1:0]  seg;
    logic [19:0] phys;
    logic        ill;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [15:0] d, s, sv;
    int n;
    bit hb, hi, bad;
    hb = (base_sel == 1) || (base_sel == 2);
    hi = (idx_sel == 1) || (idx_sel == 2);
    bad = (base_sel == 3) || (idx_sel == 3) || (!disp_en && base_sel == 0 && idx_sel == 0);
    n = int'(disp_en) + int'(hb) + int'(hi);
    if (base_sel == 0 && idx_sel == 0) d = disp;
    else if (disp_wide) d = disp;
    else d = {{8{disp[7]}}, disp[7:0]};
    s = 16'h0;
    if (disp_en) s = s + d;
    if (base_sel == 1) s = s + bx;
    if (base_sel == 2) s = s + bp;
    if (idx_sel == 1) s = s + si;
    if (idx_sel == 2) s = s + di;
    e.seg = seg_ovr_en ? seg_ovr_sel : (base_sel == 2 ? 2'd2 : 2'd3);
    case (e.seg)
      2'd0: sv = es;
      2'd1: sv = cs;
      2'd2: sv = ss;
      default: sv = ds;
    endcase
    e.ea = s;
    e.phys = 20'({sv, 4'h0} + {4'h0, s});
    e.ill = bad;
    e.lat = bad ? 1 : n;
    if (bad) begin e.ea = 0; e.phys = 0; e.seg = 0; end
    e.tag = tag;
    e.t0 = 0;
    return e;
  endfunction

  task automatic set_req(input bit de, input bit dw, input logic [15:0] dv,
                         input logic [1:0] b, input logic [1:0] x,
                         input bit oe, input logic [1:0] os);
    disp_en = de; disp_wide = dw; disp = dv; base_sel = b; idx_sel = x;
    seg_ovr_en = oe; seg_ovr_sel = os;
  endtask

  task automatic issue(input string tag, input bit de, input bit dw, input logic [15:0] dv,
                       input logic [1:0] b, input logic [1:0] x,
                       input bit oe, input logic [1:0] os);
    exp_t e;
    @(negedge clk);
    set_req(de, dw, dv, b, x, oe, os);
    e = model(tag);
    start = 1'b1;
    @(posedge clk);
    #1 e.t0 = cyc;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ea == e.ea, {e.tag, " ea"}, 32'(ea), 32'(e.ea));
        chk(seg_sel == e.seg, {e.tag, " seg_sel"}, 32'(seg_sel), 32'(e.seg));
        chk(phys == e.phys, {e.tag, " phys"}, 32'(phys), 32'(e.phys));
        chk(illegal == e.ill, {e.tag, " illegal"}, 32'(illegal), 32'(e.ill));
        chk(cyc - e.t0 == e.lat, {e.tag, " R9 latency"}, 32'(cyc - e.t0), 32'(e.lat));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    es = 16'h0100; cs = 16'h0200; ss = 16'h0300; ds = 16'h0400;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && ea == 0 && seg_sel == 0 && phys == 0,
        "R11 reset state", {busy, done, illegal, 13'h0, ea}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    bx = 16'h1000; si = 16'h0880;
    issue("R4 bx+si", 0, 0, 0, 2'd1, 2'd1, 0, 0);
    bp = 16'h1000; di = 16'h0005;
    issue("R6 bp+di+disp", 1, 1, 16'h0125, 2'd2, 2'd2, 0, 0);
    bx = 16'h2000;
    issue("R7 cs override", 1, 0, 16'h0002, 2'd1, 2'd2, 1, 2'd1);
    bx = 16'h0010;
    issue("R1 wrap", 1, 1, 16'hFFFF, 2'd1, 2'd0, 0, 0);
    issue("R3 disp only", 1, 0, 16'h1234, 2'd0, 2'd0, 0, 0);
    issue("R6 bp only", 0, 0, 0, 2'd2, 2'd0, 0, 0);
    si = 16'h4321;
    issue("R4 si only", 0, 0, 0, 2'd0, 2'd1, 0, 0);
    issue("R4 di only", 0, 0, 0, 2'd0, 2'd2, 0, 0);
    bx = 16'h0500;
    issue("R2 narrow negative", 1, 0, 16'h3380, 2'd1, 2'd0, 0, 0);
    issue("R2 narrow positive", 1, 0, 16'hAA7F, 2'd1, 2'd0, 0, 0);
    issue("R2 wide", 1, 1, 16'hAA7F, 2'd1, 2'd0, 0, 0);
    issue("R1 three terms", 1, 1, 16'h0010, 2'd1, 2'd1, 0, 0);
    issue("R6 bp+si", 0, 0, 0, 2'd2, 2'd1, 0, 0);
    issue("R7 es override on bp", 1, 0, 16'h00F0, 2'd2, 2'd2, 1, 2'd0);
    issue("R7 ss override on bx", 0, 0, 0, 2'd1, 2'd0, 1, 2'd2);
    issue("R5 bad base", 1, 1, 16'h0001, 2'd3, 2'd0, 0, 0);
    issue("R5 bad index", 0, 0, 0, 2'd1, 2'd3, 1, 2'd1);
    issue("R5 no terms", 0, 0, 0, 2'd0, 2'd0, 0, 0);
    ds = 16'hFFFF;
    issue("R8 phys wrap", 1, 1, 16'h0020, 2'd0, 2'd0, 0, 0);

    // R10: second start during busy is ignored
    begin
      exp_t e;
      bp = 16'h0100; si = 16'h0011; ds = 16'h0400;
      @(negedge clk);
      set_req(1, 1, 16'h0007, 2'd2, 2'd1, 0, 0);
      e = model("R10 in-flight result");
      start = 1'b1;
      @(posedge clk);
      #1 e.t0 = cyc;
      q.push_back(e);
      @(negedge clk);
      set_req(1, 1, 16'h5555, 2'd1, 2'd0, 1, 2'd1);
      bp = 16'h7777;
      @(negedge clk);
      start = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R10 no extra completion", 32'(q.size()), 0);
    end

    // R12: outputs hold after completion
    begin
      logic [15:0] ea_s;
      logic [19:0] ph_s;
      bx = 16'h0042;
      issue("R12 setup", 0, 0, 0, 2'd1, 2'd0, 0, 0);
      ea_s = ea; ph_s = phys;
      bx = 16'h9999;
      repeat (5) @(negedge clk);
      chk(ea == ea_s && ea == 16'h0042, "R12 ea hold", 32'(ea), 32'(16'h0042));
      chk(phys == ph_s, "R12 phys hold", 32'(phys), 32'(ph_s));
    end

    finish_run();
  end
endmodule